// File: doc/BRIEF.md
# Parallel Port Extended Control Register and Byte FIFO

This block is the extended control register of a parallel port that can run enhanced capability transfers, together with the byte FIFO behind it. A host reaches it through a plain register bus: a two-bit address, write data, combinational read data, a write strobe and a read strobe. A three-bit mode field in the extended control register sets what the block does. Writing standard mode empties the FIFO. FIFO test mode lets the host push and pop bytes through the FIFO address. Configuration mode swaps two read-only configuration bytes in at the low addresses.

The two lowest bits of the extended control register are live FIFO flags and cannot be written. Bit 2 is the service bit. The host arms it by writing 0 to it. Once it is armed, the hardware sets it, and raises `svcIrq`, when the FIFO reaches half of its depth. In the forward direction the measure is free space. In the reverse direction, selected by the data-direction input, the measure is filled bytes. The address map is: 0 = FIFO data, or configuration byte A in configuration mode. 1 = configuration byte B in configuration mode, otherwise 0x00. 2 = extended control register. 3 reads 0x00.

Top module: `ecp_ecr_top`

## Requirements
- R1: After reset the extended control register reads 0x05 (mode 000, bit 2 set, FIFO empty) and `svcIrq` is low.
- R2: A write of mode 000 (bits 7:5) to address 2 empties the FIFO, whatever the previous mode was.
- R3: Bit 0 of address 2 reads 1 when the FIFO is empty and bit 1 reads 1 when it is full. Writes never change them: with an empty FIFO, writing 0x34 or 0x37 reads back 0x35. Bits 7:2 read back as written.
- R4: In mode 110, a write to address 0 pushes a byte and a read of address 0 returns the oldest byte and pops it. Bytes come out in push order, with either value of `dataReverse`.
- R5: The FIFO holds DEPTH bytes (16 by default). A push when full is dropped. A read of address 0 when empty returns the last byte popped and leaves the FIFO empty.
- R6: In modes 110 and 011, with bit 2 at 0 and `dataReverse` low, the first clock edge at which the free space is at least DEPTH/2 sets bit 2 and raises `svcIrq`. With bit 2 at 1, no event occurs.
- R7: With bit 2 at 0 and `dataReverse` high, the event of R6 instead fires when the filled count is at least DEPTH/2.
- R8: Any write to address 2 lowers `svcIrq`. That write takes priority over an event in the same cycle.
- R9: In mode 111, address 0 reads configuration byte A = {LEVEL_IRQ, 3'b001, 4'b0000} (0x90 by default). Address 1 reads configuration byte B = {1'b0, svcIrq, IRQ_SEL[2:0], DMA_SEL[2:0]} (0x1B by default with `svcIrq` low). Writes to addresses 0 and 1 are ignored.
- R10: Outside mode 110, a write to address 0 pushes nothing and a read of address 0 pops nothing. The read still returns the head byte, or the last popped byte when the FIFO is empty.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| hostAddr | input | 2 | Register address |
| hostWdata | input | 8 | Write data |
| hostWr | input | 1 | Write strobe, one byte per cycle |
| hostRd | input | 1 | Read strobe; pops the FIFO at address 0 in test mode |
| hostRdata | output | 8 | Combinational read data for `hostAddr` |
| dataReverse | input | 1 | Data direction: 1 = FIFO is an input path |
| svcIrq | output | 1 | Service request, held until the next register write |

## Verification
The in-line assertions check these properties on every cycle:
- The FIFO count never exceeds the depth.
- A flush leaves the FIFO empty.
- A full FIFO ignores a lone push, and an empty FIFO keeps the last popped byte.
- Bit 2 falls only after a host write.
- A request rises only from the armed state and always falls after a register write.
- Push and pop strobes appear only in test mode.

Only the bench scenarios can show the rest: push order, the exact fill level at which the service event fires in each direction, the configuration byte values, the writes that must be ignored, and the read-only flag bits. The bench compares every read and the request line against a queue model on each clock.

// File: rtl/ecp_ecr_pkg.sv
package ecp_ecr_pkg;
  typedef enum logic [2:0] {
    MODE_STD   = 3'b000,
    MODE_BIDIR = 3'b001,
    MODE_FWD   = 3'b010,
    MODE_XFER  = 3'b011,
    MODE_ADDRD = 3'b100,
    MODE_RSVD  = 3'b101,
    MODE_TEST  = 3'b110,
    MODE_CFG   = 3'b111
  } ecrMode_t;

  typedef struct packed {
    logic push;
    logic pop;
    logic flush;
  } fifoCmd_t;

  localparam logic [1:0] ADDR_FIFO = 2'd0;
  localparam logic [1:0] ADDR_CFGB = 2'd1;
  localparam logic [1:0] ADDR_ECR  = 2'd2;
endpackage

// File: rtl/ecp_fifo_path.sv
module ecp_fifo_path
  import ecp_ecr_pkg::*;
#(
  parameter int DEPTH = 16,
  localparam int AW = $clog2(DEPTH),
  localparam int CW = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rstN,
  input  fifoCmd_t      cmd,
  input  logic [7:0]    wrByte,
  output logic [7:0]    rdByte,
  output logic [CW-1:0] fillCount,
  output logic          isEmpty,
  output logic          isFull
);
  logic [7:0]    mem [DEPTH];
  logic [AW-1:0] wrPtr, rdPtr;
  logic [CW-1:0] countQ;
  logic [7:0]    lastQ;
  logic          doPush, doPop;

  assign isEmpty   = (countQ == '0);
  assign isFull    = (countQ == CW'(DEPTH));
  assign fillCount = countQ;
  assign doPush    = cmd.push && !isFull && !cmd.flush;
  assign doPop     = cmd.pop && !isEmpty && !cmd.flush;
  assign rdByte    = isEmpty ? lastQ : mem[rdPtr];

  always_ff @(posedge clk) begin
    if (doPush) mem[wrPtr] <= wrByte;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      wrPtr  <= '0;
      rdPtr  <= '0;
      countQ <= '0;
      lastQ  <= '0;
    end else if (cmd.flush) begin
      wrPtr  <= '0;
      rdPtr  <= '0;
      countQ <= '0;
    end else begin
      if (doPush) wrPtr <= wrPtr + 1'b1;
      if (doPop) begin
        rdPtr <= rdPtr + 1'b1;
        lastQ <= mem[rdPtr];
      end
      countQ <= countQ + CW'(doPush) - CW'(doPop);
    end
  end

  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rstN)
    countQ <= CW'(DEPTH)); // R5
  AST_FLUSH_EMPTY: assert property (@(posedge clk) disable iff (!rstN)
    cmd.flush |=> isEmpty); // R2
  AST_FULL_DROPS: assert property (@(posedge clk) disable iff (!rstN)
    (isFull && cmd.push && !cmd.pop && !cmd.flush) |=> $stable(countQ)); // R5
  AST_EMPTY_KEEPS_LAST: assert property (@(posedge clk) disable iff (!rstN)
    (isEmpty && cmd.pop && !cmd.push) |=> (rdByte == $past(rdByte))); // R5
endmodule

// File: rtl/ecp_ecr_ctrl.sv
module ecp_ecr_ctrl
  import ecp_ecr_pkg::*;
#(
  parameter int DEPTH = 16,
  localparam int CW = $clog2(DEPTH + 1),
  localparam logic [CW-1:0] THRESH = CW'(DEPTH / 2)
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic [1:0]    hostAddr,
  input  logic [7:2]    ecrData,
  input  logic          hostWr,
  input  logic          hostRd,
  input  logic          dataReverse,
  input  logic [CW-1:0] fillCount,
  input  logic          isEmpty,
  input  logic          isFull,
  output fifoCmd_t      cmd,
  output ecrMode_t      mode,
  output logic [7:0]    ecrByte,
  output logic          pending
);
  ecrMode_t   modeQ;
  logic [1:0] spareQ;
  logic       svcBitQ;
  logic       pendQ;
  logic       ecrWr, fifoMode, levelHit, svcEvent;
  logic [CW-1:0] freeCount;

  assign ecrWr     = hostWr && (hostAddr == ADDR_ECR);
  assign fifoMode  = (modeQ == MODE_TEST) || (modeQ == MODE_XFER);
  assign freeCount = CW'(DEPTH) - fillCount;
  assign levelHit  = dataReverse ? (fillCount >= THRESH) : (freeCount >= THRESH);
  assign svcEvent  = fifoMode && !svcBitQ && levelHit;

  always_comb begin
    cmd.push  = hostWr && (hostAddr == ADDR_FIFO) && (modeQ == MODE_TEST);
    cmd.pop   = hostRd && (hostAddr == ADDR_FIFO) && (modeQ == MODE_TEST);
    cmd.flush = ecrWr && (ecrData[7:5] == MODE_STD);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      modeQ   <= MODE_STD;
      spareQ  <= '0;
      svcBitQ <= 1'b1;
      pendQ   <= 1'b0;
    end else if (ecrWr) begin
      modeQ   <= ecrMode_t'(ecrData[7:5]);
      spareQ  <= ecrData[4:3];
      svcBitQ <= ecrData[2];
      pendQ   <= 1'b0;
    end else if (svcEvent) begin
      svcBitQ <= 1'b1;
      pendQ   <= 1'b1;
    end
  end

  assign mode    = modeQ;
  assign pending = pendQ;
  assign ecrByte = {modeQ, spareQ, svcBitQ, isFull, isEmpty};

  AST_ARM_BY_HOST: assert property (@(posedge clk) disable iff (!rstN)
    $fell(svcBitQ) |-> $past(ecrWr)); // R6
  AST_EVENT_NEEDS_ARM: assert property (@(posedge clk) disable iff (!rstN)
    $rose(pendQ) |-> ($past(!svcBitQ) && svcBitQ)); // R6
  AST_WRITE_CLEARS_REQ: assert property (@(posedge clk) disable iff (!rstN)
    ecrWr |=> !pendQ); // R8
  AST_ACCESS_TEST_ONLY: assert property (@(posedge clk) disable iff (!rstN)
    (cmd.push || cmd.pop) |-> (mode == MODE_TEST)); // R10
endmodule

// File: rtl/ecp_ecr_top.sv
module ecp_ecr_top
  import ecp_ecr_pkg::*;
#(
  parameter int         DEPTH     = 16,
  parameter logic       LEVEL_IRQ = 1'b1,
  parameter logic [2:0] IRQ_SEL   = 3'd3,
  parameter logic [2:0] DMA_SEL   = 3'd3,
  localparam int CW = $clog2(DEPTH + 1)
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic [1:0] hostAddr,
  input  logic [7:0] hostWdata,
  input  logic       hostWr,
  input  logic       hostRd,
  output logic [7:0] hostRdata,
  input  logic       dataReverse,
  output logic       svcIrq
);
  fifoCmd_t      cmd;
  ecrMode_t      mode;
  logic [7:0]    fifoByte, ecrByte, cfgA, cfgB;
  logic [CW-1:0] fillCount;
  logic          isEmpty, isFull, pending;

  ecp_ecr_ctrl #(.DEPTH(DEPTH)) uCtrl (
    .clk(clk), .rstN(rstN), .hostAddr(hostAddr), .ecrData(hostWdata[7:2]),
    .hostWr(hostWr), .hostRd(hostRd), .dataReverse(dataReverse),
    .fillCount(fillCount), .isEmpty(isEmpty), .isFull(isFull),
    .cmd(cmd), .mode(mode), .ecrByte(ecrByte), .pending(pending)
  );

  ecp_fifo_path #(.DEPTH(DEPTH)) uPath (
    .clk(clk), .rstN(rstN), .cmd(cmd), .wrByte(hostWdata),
    .rdByte(fifoByte), .fillCount(fillCount), .isEmpty(isEmpty), .isFull(isFull)
  );

  assign cfgA   = {LEVEL_IRQ, 3'b001, 4'b0000};
  assign cfgB   = {1'b0, pending, IRQ_SEL, DMA_SEL};
  assign svcIrq = pending;

  always_comb begin
    case (hostAddr)
      ADDR_FIFO: hostRdata = (mode == MODE_CFG) ? cfgA : fifoByte;
      ADDR_CFGB: hostRdata = (mode == MODE_CFG) ? cfgB : 8'h00;
      ADDR_ECR:  hostRdata = ecrByte;
      default:   hostRdata = 8'h00;
    endcase
  end
endmodule

// File: tb/tb_ecp_ecr_top.sv
module tb_ecp_ecr_top;
  localparam int D = 16;
  localparam int T = D / 2;

  logic       clk = 0;
  logic       rstN = 0;
  logic [1:0] hostAddr = 2;
  logic [7:0] hostWdata = 0;
  logic       hostWr = 0, hostRd = 0, dataReverse = 0;
  logic [7:0] hostRdata;
  logic       svcIrq;

  int checks = 0, failures = 0;
  logic [7:0] lastRd;

  logic [7:0] q[$];
  int mMode = 0, mHi = 0, mSvc = 1, mPend = 0;
  logic [7:0] mLast = 0;

  ecp_ecr_top dut (
    .clk(clk), .rstN(rstN), .hostAddr(hostAddr), .hostWdata(hostWdata),
    .hostWr(hostWr), .hostRd(hostRd), .hostRdata(hostRdata),
    .dataReverse(dataReverse), .svcIrq(svcIrq)
  );

  always #4 clk = ~clk;

  // Reference model, updated on each rising edge from the inputs.
  always @(posedge clk) begin
    if (!rstN) begin
      q.delete(); mMode = 0; mHi = 0; mSvc = 1; mPend = 0; mLast = 0;
    end else begin
      int oldMode;
      bit evt;
      int lvl;
      oldMode = mMode;
      lvl = dataReverse ? q.size() : D - q.size();
      evt = (mMode == 6 || mMode == 3) && mSvc == 0 && lvl >= T;
      if (hostWr && hostAddr == 2) begin
        mMode = hostWdata[7:5]; mHi = hostWdata[4:3]; mSvc = hostWdata[2]; mPend = 0;
        if (hostWdata[7:5] == 0) q.delete();
      end else if (evt) begin
        mSvc = 1; mPend = 1;
      end
      if (oldMode == 6 && hostAddr == 0) begin
        if (hostWr && q.size() < D) q.push_back(hostWdata);
        if (hostRd && q.size() > 0) mLast = q.pop_front();
      end
    end
  end

  function automatic logic [7:0] expRd(input logic [1:0] a);
    if (mMode == 7 && a == 0) return 8'h90;
    if (mMode == 7 && a == 1) return {1'b0, mPend[0], 3'd3, 3'd3};
    if (a == 0) return (q.size() > 0) ? q[0] : mLast;
    if (a == 2) return {mMode[2:0], mHi[1:0], mSvc[0], q.size() == D, q.size() == 0};
    return 8'h00;
  endfunction

  task automatic chk(input string tag, input int got, input int exp);
    checks++;
    if (got != exp) begin
      failures++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, got, exp);
    end
  endtask

  // One bus cycle; read data and request line compared with the model.
  task automatic cyc(input logic [1:0] a, input logic [7:0] d, input logic w, input logic r);
    @(negedge clk);
    hostAddr = a; hostWdata = d; hostWr = w; hostRd = r;
    #1;
    lastRd = hostRdata;
    chk(a == 0 ? "R4 model read" : (a == 1 ? "R9 model read" : "R3 model read"),
        hostRdata, expRd(a));
    chk("R6 model request", svcIrq, mPend);
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    cyc(a, d, 1, 0);
  endtask

  task automatic idle();
    cyc(2, 0, 0, 0);
  endtask

  task automatic rdChk(input logic [1:0] a, input logic [7:0] e, input string tag);
    cyc(a, 0, 0, 1);
    chk(tag, lastRd, e);
  endtask

  task automatic irqChk(input logic e, input string tag);
    idle();
    chk(tag, svcIrq, e);
  endtask

  initial begin
    #(8 * 200000);
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1;
    rdChk(2, 8'h05, "R1 reset value");
    chk("R1 reset request", svcIrq, 0);

    wr(2, 8'h34); rdChk(2, 8'h35, "R3 flag bits read-only");
    wr(2, 8'h37); rdChk(2, 8'h35, "R3 flag write ignored");

    wr(2, 8'hC4);
    wr(0, 8'h11); wr(0, 8'h22); wr(0, 8'h33);
    rdChk(2, 8'hC4, "R3 not empty");
    rdChk(0, 8'h11, "R4 first pop");
    dataReverse = 1;
    rdChk(0, 8'h22, "R4 pop reverse dir");
    rdChk(0, 8'h33, "R4 third pop");
    rdChk(0, 8'h33, "R5 empty pop last byte");
    rdChk(2, 8'hC5, "R5 still empty");
    dataReverse = 0;

    for (int i = 0; i < D + 1; i++) wr(0, 8'(8'h40 + i));
    rdChk(2, 8'hC6, "R5 full flag");
    rdChk(0, 8'h40, "R5 oldest after fill");
    for (int i = 1; i < D - 1; i++) rdChk(0, 8'(8'h40 + i), "R4 drain order");
    rdChk(0, 8'h4F, "R5 last stored byte");
    rdChk(2, 8'hC5, "R5 overflow dropped");

    wr(2, 8'h24); wr(0, 8'h99);
    rdChk(0, 8'h4F, "R10 no push outside test");
    wr(2, 8'hC4);
    rdChk(2, 8'hC5, "R10 still empty");

    wr(0, 8'h01); wr(0, 8'h02); wr(0, 8'h03);
    wr(2, 8'h04);
    rdChk(2, 8'h05, "R2 flush on std mode");
    wr(2, 8'hC4);
    rdChk(2, 8'hC5, "R2 empty after return");

    wr(2, 8'hC0);
    rdChk(2, 8'hC1, "R6 armed");
    rdChk(2, 8'hC5, "R6 bit set on free space");
    irqChk(1, "R6 request raised");
    wr(2, 8'hC4);
    irqChk(0, "R8 write clears request");

    for (int i = 0; i < 9; i++) wr(0, 8'(8'h60 + i));
    wr(2, 8'hC0);
    idle(); idle();
    irqChk(0, "R6 below free threshold");
    rdChk(0, 8'h60, "R6 pop to threshold");
    idle();
    irqChk(1, "R6 fires at half free");

    wr(2, 8'h04); wr(2, 8'hC4);
    dataReverse = 1;
    wr(2, 8'hC0);
    idle(); idle();
    irqChk(0, "R7 empty no event reverse");
    for (int i = 0; i < T; i++) wr(0, 8'(8'h70 + i));
    idle();
    irqChk(1, "R7 fires at half filled");
    rdChk(2, 8'hC4, "R7 bit set");

    dataReverse = 0;
    wr(2, 8'hF4);
    rdChk(0, 8'h90, "R9 config A");
    rdChk(1, 8'h1B, "R9 config B");
    wr(0, 8'h77); wr(1, 8'h00);
    rdChk(1, 8'h1B, "R9 config write ignored");
    rdChk(2, 8'hF4, "R9 fifo kept");
    wr(2, 8'hC4);
    rdChk(0, 8'h70, "R9 no push in config mode");
    rdChk(1, 8'h00, "R9 addr1 outside config");

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule